// File: doc/BRIEF.md
# Frequency Window Detector

This block steers a clock-recovery loop while it is still acquiring. It measures the recovered oscillator against a reference clock over a fixed window, sorts the result into three classes, and converts that result into pulses for the loop filter. The classes are too slow, too fast and in window. The measurement interval is `ref_div_i` reference clocks long. The oscillator arrives as a free-running divided clock, `osc_i`, which is asynchronous to the reference. Inside the reference domain the block synchronizes it, detects its rising edges, and divides the edge count by `osc_div_i` before the count is taken.

At the last cycle of each interval the count is compared with the bounds `win_lo_i` and `win_hi_i`. The result is registered and then held for the whole of the next interval. A count below the window means the oscillator is too slow and is reported as an up request. A count above the window means it is too fast and is reported as a down request. A non-OK result fires a single pulse of `pulse_len_i` reference cycles on `up_o` or `dn_o`. The block also drives the select of the phase-detector path. Phase-detector pulses reach the loop only while the result is in window. While the loop is still being pulled in frequency, they are blocked.

Top module: `freq_window_det`

## Requirements
- R1: While `rst_ni` is low, and until the first interval has ended, `slow_o`, `fast_o`, `up_o` and `dn_o` are 0 and `pd_sel_o` is 1.
- R2: An interval is `ref_div_i` reference cycles long, counted from the first clock edge after reset. The result outputs change only at the clock edge that ends an interval, and they hold their value for the whole of the following interval.
- R3: Let the interval's final count be C. If C < `win_lo_i`, the result is `slow_o`=1, `fast_o`=0. If C > `win_hi_i`, the result is `fast_o`=1, `slow_o`=0. If C lies within the bounds, inclusive at both ends, the result is OK, with both outputs 0. `slow_o` and `fast_o` are never high together.
- R4: A slow result drives `up_o` high for exactly `pulse_len_i` cycles, starting in the cycle that follows the end of the interval. A fast result does the same on `dn_o`. An OK result produces no pulse, and `pulse_len_i`=0 produces no pulse. The bench uses `pulse_len_i` < `ref_div_i`.
- R5: `pd_sel_o` is 1 exactly when the held result is OK. `pd_up_o` equals `pd_up_i & pd_sel_o`, and `pd_dn_o` equals `pd_dn_i & pd_sel_o`.
- R6: The count clears at the start of every interval, so no ticks carry over from one interval into the next.
- R7: C is the number of detected `osc_i` rising edges divided by `osc_div_i`, rounded down. The partial remainder is discarded when the interval ends. `osc_div_i` of 0 acts as 1.
- R8: `osc_i` may change at any time relative to the clock. Each rising edge is counted exactly once, provided `osc_i` stays high for at least one clock and low for at least one clock.
- R9: C saturates at 2^CNT_W-1 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_i | input | 1 | Divided oscillator clock, asynchronous |
| ref_div_i | input | DIV_W | Interval length in reference cycles (n) |
| osc_div_i | input | PRE_W | Edge prescale factor (x) |
| win_lo_i | input | CNT_W | Lower window bound, inclusive |
| win_hi_i | input | CNT_W | Upper window bound, inclusive |
| pulse_len_i | input | PLS_W | Correction pulse length in reference cycles |
| pd_up_i | input | 1 | Phase-detector up request |
| pd_dn_i | input | 1 | Phase-detector down request |
| slow_o | output | 1 | Held result: oscillator too slow |
| fast_o | output | 1 | Held result: oscillator too fast |
| up_o | output | 1 | Up correction pulse to the loop filter |
| dn_o | output | 1 | Down correction pulse to the loop filter |
| pd_sel_o | output | 1 | 1 selects the phase-detector path |
| pd_up_o | output | 1 | Gated phase-detector up |
| pd_dn_o | output | 1 | Gated phase-detector down |

## Verification
Several things happen in the cycle that ends an interval. The count is cleared, the result register is updated, and the pulse former is reloaded. A prescaled tick can also arrive in that same cycle, and it must still be included in the count being judged. Other edges that arrive in that cycle must not leak into the next interval. The bench provokes this by running back-to-back intervals without an idle interval between them: a slow result followed by a fast one, and a saturated count followed by a normal one. For each interval it judges three things: the held classification, the gating of the phase-detector path, and the number of cycles that `up_o` and `dn_o` are high.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    RES_OK   = 2'd0,
    RES_SLOW = 2'd1,
    RES_FAST = 2'd2
  } fwd_res_e;
endpackage

// File: rtl/fwd_sync_edge.sv
module fwd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  // edge taken after STAGES synchronizing flops
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/fwd_prescale.sv
module fwd_prescale #(
  parameter int PRE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] div_i,
  input  logic             rise_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic             last;

  assign last   = (div_i <= PRE_W'(1)) || (cnt_q >= div_i - PRE_W'(1));
  assign tick_o = rise_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (rise_i) cnt_q <= last ? '0 : cnt_q + PRE_W'(1);
  end
endmodule

// File: rtl/fwd_interval.sv
module fwd_interval #(
  parameter int DIV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             end_o
);
  logic [DIV_W-1:0] cnt_q;

  assign end_o = (div_i <= DIV_W'(1)) || (cnt_q >= div_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= end_o ? '0 : cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/fwd_pulse.sv
module fwd_pulse #(
  parameter int PLS_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PLS_W-1:0] len_i,
  output logic             active_o
);
  logic [PLS_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - PLS_W'(1);
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/freq_window_det.sv
module freq_window_det
  import fwd_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int DIV_W       = 10,
  parameter int PRE_W       = 4,
  parameter int PLS_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_i,
  input  logic [DIV_W-1:0] ref_div_i,
  input  logic [PRE_W-1:0] osc_div_i,
  input  logic [CNT_W-1:0] win_lo_i,
  input  logic [CNT_W-1:0] win_hi_i,
  input  logic [PLS_W-1:0] pulse_len_i,
  input  logic             pd_up_i,
  input  logic             pd_dn_i,
  output logic             slow_o,
  output logic             fast_o,
  output logic             up_o,
  output logic             dn_o,
  output logic             pd_sel_o,
  output logic             pd_up_o,
  output logic             pd_dn_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             osc_rise;
  logic             tick;
  logic             iv_end;
  logic             pls_active;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] total;
  fwd_res_e         res_q;
  fwd_res_e         res_d;

  fwd_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (osc_i),
    .rise_o  (osc_rise)
  );

  fwd_prescale #(.PRE_W(PRE_W)) i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (iv_end),
    .div_i  (osc_div_i),
    .rise_i (osc_rise),
    .tick_o (tick)
  );

  fwd_interval #(.DIV_W(DIV_W)) i_iv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (ref_div_i),
    .end_o  (iv_end)
  );

  // tick in the closing cycle still belongs to the closing interval
  assign total = (tick && cnt_q != CNT_MAX) ? cnt_q + CNT_W'(1) : cnt_q;

  always_comb begin
    if (total < win_lo_i)      res_d = RES_SLOW;
    else if (total > win_hi_i) res_d = RES_FAST;
    else                       res_d = RES_OK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      res_q <= RES_OK;
    end else if (iv_end) begin
      cnt_q <= '0;
      res_q <= res_d;
    end else begin
      cnt_q <= total;
    end
  end

  fwd_pulse #(.PLS_W(PLS_W)) i_pls (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (iv_end && res_d != RES_OK),
    .len_i    (pulse_len_i),
    .active_o (pls_active)
  );

  assign slow_o   = (res_q == RES_SLOW);
  assign fast_o   = (res_q == RES_FAST);
  assign up_o     = pls_active & slow_o;
  assign dn_o     = pls_active & fast_o;
  assign pd_sel_o = (res_q == RES_OK);
  assign pd_up_o  = pd_up_i & pd_sel_o;
  assign pd_dn_o  = pd_dn_i & pd_sel_o;
endmodule

// File: rtl/fwd_checker.sv
module fwd_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             iv_end,
  input logic [CNT_W-1:0] cnt_q,
  input logic             slow_o,
  input logic             fast_o,
  input logic             up_o,
  input logic             dn_o,
  input logic             pd_sel_o,
  input logic             pd_up_o,
  input logic             pd_dn_o
);
  AST_RES_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iv_end |=> $stable({slow_o, fast_o})); // R2

  AST_RES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(slow_o && fast_o)); // R3

  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o)); // R4

  AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(up_o) || $rose(dn_o)) |-> $past(iv_end)); // R4

  AST_PD_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_sel_o |-> (!pd_up_o && !pd_dn_o)); // R5

  AST_SEL_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_sel_o |-> (!slow_o && !fast_o)); // R5

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iv_end |=> (cnt_q == '0)); // R6
endmodule

bind freq_window_det fwd_checker #(.CNT_W(CNT_W)) i_fwd_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .iv_end   (iv_end),
  .cnt_q    (cnt_q),
  .slow_o   (slow_o),
  .fast_o   (fast_o),
  .up_o     (up_o),
  .dn_o     (dn_o),
  .pd_sel_o (pd_sel_o),
  .pd_up_o  (pd_up_o),
  .pd_dn_o  (pd_dn_o)
);

// File: tb/test_freq_window_det.sv
module test_freq_window_det;
  localparam int CNT_W = 4;
  localparam int DIV_W = 8;
  localparam int PRE_W = 4;
  localparam int PLS_W = 6;
  localparam int N     = 64;
  localparam int LO    = 5;
  localparam int HI    = 9;
  localparam int CMAX  = (1 << CNT_W) - 1;

  typedef struct {
    int iv;
    bit slow;
    bit fast;
    int len;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic osc = 1'b0;
  logic [PRE_W-1:0] osc_div = PRE_W'(1);
  logic [PLS_W-1:0] plen = PLS_W'(3);
  logic pd_up_i = 1'b1, pd_dn_i = 1'b1;
  logic slow_o, fast_o, up_o, dn_o, pd_sel_o, pd_up_o, pd_dn_o;

  int cyc = -1;
  int n_chk = 0, n_bad = 0;
  exp_t exp_q[$];
  exp_t prev;
  bit have_prev = 0;
  int up_cnt = 0, dn_cnt = 0;

  always #10 clk = ~clk;

  freq_window_det #(.CNT_W(CNT_W), .DIV_W(DIV_W), .PRE_W(PRE_W), .PLS_W(PLS_W)) i_freq_window_det (
    .clk_i(clk), .rst_ni(rst_ni), .osc_i(osc),
    .ref_div_i(DIV_W'(N)), .osc_div_i(osc_div),
    .win_lo_i(CNT_W'(LO)), .win_hi_i(CNT_W'(HI)), .pulse_len_i(plen),
    .pd_up_i(pd_up_i), .pd_dn_i(pd_dn_i),
    .slow_o(slow_o), .fast_o(fast_o), .up_o(up_o), .dn_o(dn_o),
    .pd_sel_o(pd_sel_o), .pd_up_o(pd_up_o), .pd_dn_o(pd_dn_o)
  );

  always @(posedge clk) cyc <= rst_ni ? cyc + 1 : -1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, expv, $time);
    end
  endtask

  // monitor: judge each interval at the negedge after its closing edge
  always @(negedge clk) begin
    if (rst_ni && cyc >= 0) begin
      if (cyc % N == N - 2 && have_prev)
        check({slow_o, fast_o} == {prev.slow, prev.fast}, {"R2 held ", prev.tag},
              {slow_o, fast_o}, {prev.slow, prev.fast});
      if (cyc % N == N - 1) begin
        if (have_prev) begin
          check(up_cnt == (prev.slow ? prev.len : 0), {"R4 up pulse ", prev.tag}, up_cnt,
                prev.slow ? prev.len : 0);
          check(dn_cnt == (prev.fast ? prev.len : 0), {"R4 dn pulse ", prev.tag}, dn_cnt,
                prev.fast ? prev.len : 0);
        end
        have_prev = 0;
        if (exp_q.size() > 0 && exp_q[0].iv == cyc / N) begin
          prev = exp_q.pop_front();
          have_prev = 1;
          check({slow_o, fast_o} == {prev.slow, prev.fast}, {"R3 class ", prev.tag},
                {slow_o, fast_o}, {prev.slow, prev.fast});
          check({pd_sel_o, pd_up_o, pd_dn_o} == {3{~(prev.slow | prev.fast)}},
                {"R5 gating ", prev.tag}, {pd_sel_o, pd_up_o, pd_dn_o},
                {3{~(prev.slow | prev.fast)}});
        end
        up_cnt = int'(up_o);
        dn_cnt = int'(dn_o);
      end else begin
        up_cnt += int'(up_o);
        dn_cnt += int'(dn_o);
      end
    end
  end

  // driver: one interval of 'edges' osc pulses, expected result queued
  task automatic run_iv(input int edges, input int x, input int len, input string tag);
    exp_t e;
    int c;
    @(negedge clk);
    while (cyc < 0 || cyc % N != N - 1) @(negedge clk);
    osc_div = PRE_W'(x);
    plen = PLS_W'(len);
    c = edges / ((x == 0) ? 1 : x);
    if (c > CMAX) c = CMAX;
    e.iv = cyc / N + 1;
    e.slow = (c < LO);
    e.fast = (c > HI);
    e.len = len;
    e.tag = tag;
    exp_q.push_back(e);
    for (int i = 0; i < edges; i++) begin
      osc = 1'b1;
      @(negedge clk);
      osc = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic run_all;
    repeat (3) @(negedge clk);
    check({slow_o, fast_o, up_o, dn_o, pd_sel_o} == 5'b00001, "R1 in reset",
          {slow_o, fast_o, up_o, dn_o, pd_sel_o}, 1);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    check({slow_o, fast_o, up_o, dn_o, pd_sel_o} == 5'b00001, "R1 after release",
          {slow_o, fast_o, up_o, dn_o, pd_sel_o}, 1);
    run_iv(7, 1, 3, "R3 mid window");
    run_iv(4, 1, 3, "R3 below window");
    run_iv(12, 1, 5, "R3 above window after slow");
    run_iv(5, 1, 2, "R3 lower bound inclusive");
    run_iv(9, 1, 2, "R3 upper bound inclusive");
    run_iv(10, 1, 4, "R3 one above upper");
    run_iv(0, 1, 6, "R8 no edges");
    run_iv(11, 2, 3, "R7 remainder dropped");
    run_iv(9, 2, 3, "R7 floor below");
    run_iv(20, 1, 7, "R9 saturate");
    run_iv(6, 1, 3, "R6 clear after saturation");
    run_iv(6, 0, 3, "R7 zero factor");
    run_iv(8, 3, 0, "R4 zero length");
    run_iv(24, 3, 2, "R8 edges counted once");
    run_iv(7, 1, 3, "flush");
    repeat (2 * N + 4) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule